// File: doc/BRIEF.md
# RTC Interrupt Event and Alarm Flag Controller

This block turns the timing events of a PC-style real-time clock into three maskable interrupt sources. The sources are a periodic tick, an alarm match on hours, minutes and seconds, and the end of each update cycle. An event latches a sticky flag in an event register. Whenever a latched flag meets its enable, a summary flag is set and the interrupt request line is driven. A host polls or services the block through a small synchronous register interface. One read of the event register acknowledges every pending event together.

The divider and the time-keeping counters sit outside the block. They deliver a one-cycle `upd_done` strobe when an update cycle ends and a one-cycle `per_tick` strobe once every selected periodic interval. They also provide the present time bytes. The alarm bytes arrive as inputs. An alarm byte whose two top bits are both set matches any value, so the alarm can fire once per day, hour, minute or second. The interrupt output is an enable for an external active-low open-drain driver: 1 means the line is pulled low.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset has the following effects. `irq_drive` is 0. The event register reads 0x00. Control bits 6 to 3 read 0. `rd_data` is 0.
- R2: The event register is at address 2 and is read-only. Bit 7 is the summary flag, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3 to 0 read 0, and a write to address 2 changes nothing.
- R3: The control register is at address 1 and is read/write. Bit 7 is transfer inhibit, bit 6 the periodic enable, bit 5 the alarm enable, bit 4 the update enable and bit 3 the square-wave enable. Bits 2 to 0 are general control bits. A read returns the last value written, subject to R11.
- R4: An `upd_done` strobe sets the update flag, whatever the enables hold.
- R5: A `per_tick` strobe sets the periodic flag.
- R6: The alarm flag is set only by an `upd_done` strobe, and only when each alarm byte equals its present-time byte.
- R7: An alarm byte with bits 7 and 6 both 1 is left out of the comparison. A byte with only bit 7 set is still compared.
- R8: The summary flag and `irq_drive` become 1 when at least one flag is set together with its enable. Both are set on the edge that sets the flag. If an enable is written while its flag is already set, both are set one cycle after the write. Flags with no enable leave `irq_drive` at 0.
- R9: A read of address 2 returns the register as it stood before the read on `rd_data` after that edge. On the same edge it clears all four flags and releases `irq_drive`.
- R10: An event strobe in the same cycle as a read of address 2 is kept. Its flag is set after the read, and `irq_drive` is set if the event is enabled.
- R11: A control write with bit 7 set forces the update enable to 0, so an update interrupt needs transfer inhibit 0.
- R12: Address 3 reads `ram_ok` in bit 7 and 0 in bits 6 to 0. Address 0 reads 0x00.
- R13: Reset leaves control bit 7 and bits 2 to 0 at their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| upd_done | input | 1 | One-cycle strobe: update cycle ended |
| per_tick | input | 1 | One-cycle strobe: periodic interval elapsed |
| cur_hour | input | 8 | Present hours byte |
| cur_min | input | 8 | Present minutes byte |
| cur_sec | input | 8 | Present seconds byte |
| alm_hour | input | 8 | Hours alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_sec | input | 8 | Seconds alarm byte |
| ram_ok | input | 1 | Backup source valid |
| irq_drive | output | 1 | 1 = pull the interrupt line low |

## Verification
Event flags and `irq_drive` change on the clock edge that samples a strobe. Read data appears on the edge that samples `rd_en`. A change of enable reaches `irq_drive` one edge after the write. The bench drives every input at a falling edge and waits for the next rising edge. It samples `irq_drive` two nanoseconds later. A monitor compares `rd_data` at the following falling edge against the value queued when the read was issued. Simultaneous read-and-event cases are placed so that the pre-read value and the kept flag are each checked in their own cycle.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the RTC interrupt flag controller: register
// addresses, bit positions and the alarm don't-care code.
package rtc_irq_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_EVT  = 2'd2,
        SEL_STS  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_INH = 7;
    localparam int CTL_PIE = 6;
    localparam int CTL_AIE = 5;
    localparam int CTL_UIE = 4;
    localparam int CTL_SQE = 3;
    localparam int CTL_GEN_W = 3;

    // flag vector indices (periodic, alarm, update)
    localparam int FLG_PF = 2;
    localparam int FLG_AF = 1;
    localparam int FLG_UF = 0;
    localparam int NUM_FLG = 3;

    // top two bits of an alarm byte equal to this mean "any value"
    localparam logic [1:0] ALM_DONT_CARE = 2'b11;
endpackage

// File: rtl/rtc_alarm_cmp.sv
// Alarm comparator. Compares NUM_FIELDS present-time bytes with their
// alarm bytes. A field whose alarm byte carries the don't-care code in
// its two top bits always matches. Purely combinational.
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int NUM_FIELDS = 3,
    parameter int FIELD_W    = BYTE_W
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_vec,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alm_vec,
    output logic                          all_hit
);
    logic [NUM_FIELDS-1:0] field_hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [FIELD_W-1:0] cur_b;
        logic [FIELD_W-1:0] alm_b;
        assign cur_b = cur_vec[g*FIELD_W +: FIELD_W];
        assign alm_b = alm_vec[g*FIELD_W +: FIELD_W];
        // one field matches when ignored or equal
        assign field_hit[g] = (alm_b[FIELD_W-1 -: 2] == ALM_DONT_CARE) ||
                              (alm_b == cur_b);
    end

    assign all_hit = &field_hit;
endmodule

// File: rtl/rtc_irq_flags.sv
// Sticky event flags and summary flag. Set requests win over a
// same-cycle clear, so no event is lost. The summary flag is set on the
// same edge as an enabled flag. It is cleared only by the read-clear.
// Assumes set strobes are single-cycle.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLG-1:0] set_req,
    input  logic [NUM_FLG-1:0] enable,
    input  logic               rd_clr,
    output logic [NUM_FLG-1:0] flags,
    output logic               intf
);
    logic [NUM_FLG-1:0] flags_q, flags_d;
    logic               intf_q, intf_d;

    // next-state: clear on read, then merge new events and summary
    always_comb begin
        flags_d = (rd_clr ? '0 : flags_q) | set_req;
        intf_d  = (rd_clr ? 1'b0 : intf_q) | (|(enable & flags_d));
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            intf_q  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            intf_q  <= intf_d;
        end
    end

    assign flags = flags_q;
    assign intf  = intf_q;
endmodule

// File: rtl/rtc_irq_regs.sv
// Host register interface: control register, read multiplexer and
// event read-clear strobe. Reset clears only the enable bits. Inhibit
// and general bits keep their values. Read data is registered.
module rtc_irq_regs
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [NUM_FLG-1:0] flags,
    input  logic               intf,
    input  logic               ram_ok,
    output logic [BYTE_W-1:0]  ctl_byte,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rd_clr
);
    logic                 ctl_wr;
    logic                 pie_q, aie_q, uie_q, sqe_q;
    logic                 inh_q;
    logic [CTL_GEN_W-1:0] gen_q;
    logic [BYTE_W-1:0]    rd_mux;
    logic [BYTE_W-1:0]    rd_q;

    assign ctl_wr = wr_en && (addr == SEL_CTL);
    assign rd_clr = rd_en && (addr == SEL_EVT);

    // enable bits: cleared by reset, update enable blocked by inhibit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pie_q <= 1'b0;
            aie_q <= 1'b0;
            uie_q <= 1'b0;
            sqe_q <= 1'b0;
        end else if (ctl_wr) begin
            pie_q <= wr_data[CTL_PIE];
            aie_q <= wr_data[CTL_AIE];
            uie_q <= wr_data[CTL_UIE] & ~wr_data[CTL_INH];
            sqe_q <= wr_data[CTL_SQE];
        end
    end

    // inhibit and general bits: not touched by reset
    always_ff @(posedge clk) begin
        if (ctl_wr) begin
            inh_q <= wr_data[CTL_INH];
            gen_q <= wr_data[CTL_GEN_W-1:0];
        end
    end

    assign ctl_byte = {inh_q, pie_q, aie_q, uie_q, sqe_q, gen_q};

    // read multiplexer
    always_comb begin
        case (addr)
            SEL_CTL: rd_mux = ctl_byte;
            SEL_EVT: rd_mux = {intf, flags[FLG_PF], flags[FLG_AF],
                               flags[FLG_UF], 4'b0000};
            SEL_STS: rd_mux = {ram_ok, 7'b0000000};
            default: rd_mux = '0;
        endcase
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
// RTC interrupt flag controller top. Joins the alarm comparator, the
// flag store and the host registers. Assumes the strobes last one
// cycle and the time and alarm bytes are stable while upd_done is high.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int NUM_FIELDS = 3,
    parameter int FIELD_W    = BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               upd_done,
    input  logic               per_tick,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic               ram_ok,
    output logic               irq_drive
);
    localparam int VEC_W = NUM_FIELDS * FIELD_W;

    logic [VEC_W-1:0]   cur_vec, alm_vec;
    logic               alarm_hit;
    logic [NUM_FLG-1:0] set_req, enable, flags;
    logic               intf, rd_clr;
    logic [BYTE_W-1:0]  ctl_byte;

    assign cur_vec = {cur_hour, cur_min, cur_sec};
    assign alm_vec = {alm_hour, alm_min, alm_sec};

    rtc_alarm_cmp #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_cmp (
        .cur_vec (cur_vec),
        .alm_vec (alm_vec),
        .all_hit (alarm_hit)
    );

    // event requests in flag order {periodic, alarm, update}
    assign set_req = {per_tick, upd_done & alarm_hit, upd_done};
    assign enable  = {ctl_byte[CTL_PIE], ctl_byte[CTL_AIE],
                      ctl_byte[CTL_UIE] & ~ctl_byte[CTL_INH]};

    rtc_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .enable  (enable),
        .rd_clr  (rd_clr),
        .flags   (flags),
        .intf    (intf)
    );

    rtc_irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .flags    (flags),
        .intf     (intf),
        .ram_ok   (ram_ok),
        .ctl_byte (ctl_byte),
        .rd_data  (rd_data),
        .rd_clr   (rd_clr)
    );

    assign irq_drive = intf;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
// Property checker for rtc_irq_ctrl, attached by bind below.
module rtc_irq_ctrl_chk
    import rtc_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [BYTE_W-1:0]  rd_data,
    input logic               upd_done,
    input logic               per_tick,
    input logic               ram_ok,
    input logic               irq_drive,
    input logic [NUM_FLG-1:0] flags,
    input logic [BYTE_W-1:0]  ctl_byte
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_drive && ctl_byte[6:3] == 4'b0000 && flags == '0));

    p_uf_on_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flags[FLG_UF]);

    p_pf_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> flags[FLG_PF]);

    p_af_needs_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !flags[FLG_AF]) |=> !flags[FLG_AF]);

    p_quiet_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byte[6:4] == 3'b000 && !irq_drive) |=> !irq_drive);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == SEL_EVT && !upd_done && !per_tick)
            |=> (!irq_drive && flags == '0));

    p_event_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == SEL_EVT && upd_done) |=> flags[FLG_UF]);

    p_inhibit_blocks_uie_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_byte[CTL_INH] |-> !ctl_byte[CTL_UIE]);

    p_status_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == SEL_STS) |=> (rd_data == {$past(ram_ok), 7'b0000000}));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .rd_data   (rd_data),
    .upd_done  (upd_done),
    .per_tick  (per_tick),
    .ram_ok    (ram_ok),
    .irq_drive (irq_drive),
    .flags     (flags),
    .ctl_byte  (ctl_byte)
);

// File: tb/rtc_irq_ctrl_test.sv
// Scoreboard bench for rtc_irq_ctrl: read tasks queue expected values,
// a monitor compares rd_data at the falling edge after each read.
module rtc_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       upd_done = 1'b0, per_tick = 1'b0;
    logic [7:0] cur_hour = 8'h12, cur_min = 8'h30, cur_sec = 8'h45;
    logic [7:0] alm_hour = 8'h01, alm_min = 8'h02, alm_sec = 8'h03;
    logic       ram_ok = 1'b1;
    logic       irq_drive;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] msk;
        string      req;
    } item_t;

    item_t exp_q[$];
    bit    rd_pending = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;

    localparam logic [1:0] A_CTL = 2'd1, A_EVT = 2'd2, A_STS = 2'd3;

    always #4 clk = ~clk;   // 125 MHz

    rtc_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .upd_done(upd_done), .per_tick(per_tick),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .ram_ok(ram_ok), .irq_drive(irq_drive)
    );

    // monitor: compare read data against the queued expectation
    always @(negedge clk) begin
        if (rd_pending) begin
            item_t it;
            rd_pending = 0;
            it = exp_q.pop_front();
            n_run++;
            if ((rd_data & it.msk) !== (it.exp & it.msk)) begin
                n_fail++;
                $display("FAIL %s: rd_data actual %h expected %h (mask %h)",
                         it.req, rd_data, it.exp, it.msk);
            end
        end
    end

    task automatic op(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] wd, input logic up, input logic pt,
                      input logic [7:0] e, input logic [7:0] m, input string req);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wr_data = wd;
        upd_done = up; per_tick = pt;
        if (r) exp_q.push_back('{e, m, req});
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; upd_done = 0; per_tick = 0;
        if (r) rd_pending = 1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        op(1, 0, a, d, 0, 0, 8'h00, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
        op(0, 1, a, 8'h00, 0, 0, e, 8'hFF, req);
    endtask

    task automatic ev(input logic up, input logic pt);
        op(0, 0, 2'd0, 8'h00, up, pt, 8'h00, 8'h00, "");
    endtask

    task automatic chk_irq(input logic e, input string req);
        n_run++;
        if (irq_drive !== e) begin
            n_fail++;
            $display("FAIL %s: irq_drive actual %b expected %b", req, irq_drive, e);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset state
        chk_irq(0, "R1 irq after reset");
        rd(A_EVT, 8'h00, "R1 event after reset");
        op(0, 1, A_CTL, 8'h00, 0, 0, 8'h00, 8'h78, "R1 enables after reset");

        // R3 / R11: control readback and inhibit interplay
        wr(A_CTL, 8'h8F);
        rd(A_CTL, 8'h8F, "R3 control readback");
        wr(A_CTL, 8'h9F);
        rd(A_CTL, 8'h8F, "R11 inhibit forces update enable low");
        wr(A_CTL, 8'h7B);
        rd(A_CTL, 8'h7B, "R3 enables readback");

        // R13: reset keeps inhibit and general bits
        wr(A_CTL, 8'hEB);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1;
        rd(A_CTL, 8'h83, "R13 reset keeps inhibit and general bits");

        // R4, R9: update flag, read clears
        wr(A_CTL, 8'h03);
        ev(1, 0);
        chk_irq(0, "R8 no enable no irq");
        rd(A_EVT, 8'h10, "R4 update flag");
        rd(A_EVT, 8'h00, "R9 flags cleared by read");

        // R5: periodic flag
        ev(0, 1);
        rd(A_EVT, 8'h40, "R5 periodic flag");

        // R6 / R7: alarm comparison
        alm_hour = 8'h12; alm_min = 8'h30; alm_sec = 8'h45;
        ev(0, 0);
        rd(A_EVT, 8'h00, "R6 no alarm without update strobe");
        ev(1, 0);
        rd(A_EVT, 8'h30, "R6 full match sets alarm flag");
        alm_hour = 8'h11;
        ev(1, 0);
        rd(A_EVT, 8'h10, "R6 hour mismatch no alarm");
        alm_hour = 8'hC0;
        ev(1, 0);
        rd(A_EVT, 8'h30, "R7 hour byte dont care");
        alm_hour = 8'hFF; alm_min = 8'hC5; alm_sec = 8'hD2;
        ev(1, 0);
        rd(A_EVT, 8'h30, "R7 all bytes dont care");
        alm_hour = 8'h80;
        ev(1, 0);
        rd(A_EVT, 8'h10, "R7 single top bit still compared");

        // R8: enables and summary flag
        wr(A_CTL, 8'h43);
        ev(0, 1);
        chk_irq(1, "R8 periodic enabled irq");
        rd(A_EVT, 8'hC0, "R8 summary with periodic");
        chk_irq(0, "R9 read releases irq");
        ev(1, 0);
        chk_irq(0, "R8 update flag without its enable");
        rd(A_EVT, 8'h10, "R8 update flag only");
        wr(A_CTL, 8'h13);
        ev(1, 0);
        chk_irq(1, "R8 update enabled irq");
        rd(A_EVT, 8'h90, "R2 summary and update bits");
        wr(A_CTL, 8'h03);
        ev(0, 1);
        chk_irq(0, "R8 periodic flag no enable");
        wr(A_CTL, 8'h43);
        ev(0, 0);
        chk_irq(1, "R8 late enable raises irq");
        rd(A_EVT, 8'hC0, "R8 late enable summary");

        // R10: event in the same cycle as a read
        wr(A_CTL, 8'h03);
        ev(0, 1);
        op(0, 1, A_EVT, 8'h00, 1, 0, 8'h40, 8'hFF, "R10 read returns pre-read value");
        rd(A_EVT, 8'h10, "R10 same-cycle update kept");
        wr(A_CTL, 8'h13);
        op(0, 1, A_EVT, 8'h00, 1, 0, 8'h00, 8'hFF, "R10 read before kept event");
        chk_irq(1, "R10 kept enabled event drives irq");
        rd(A_EVT, 8'h90, "R10 kept event with summary");

        // R2: writes to the event register ignored
        wr(A_CTL, 8'h73);
        wr(A_EVT, 8'hFF);
        chk_irq(0, "R2 write to event register no irq");
        rd(A_EVT, 8'h00, "R2 write to event register ignored");

        // R12: status and unmapped reads
        ram_ok = 1'b1;
        rd(A_STS, 8'h80, "R12 backup valid");
        ram_ok = 1'b0;
        rd(A_STS, 8'h00, "R12 backup depleted");
        rd(2'd0, 8'h00, "R12 address 0 reads zero");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule